// File: doc/BRIEF.md
# March-Algorithm Memory Self-Test Sequencer

This block drives a single-port, word-wide synchronous SRAM through a chosen march algorithm and reports whether every read returned the expected word. A march is a list of elements. Each element walks the whole address range in one direction and, at every address, performs a short fixed list of reads and writes. Each operation uses a data background word or its bitwise complement. One operation is issued per clock cycle, and the memory answers reads one cycle later.

Three algorithm families are built in. A six-operation-per-address march and a fourteen-operation-per-address walking march are each repeated once for every standard background. A merged mode runs a ten-operation march once with the all-zero background and then a five-operation march for each of the other backgrounds. The first miscompare freezes its address, element number and background number. The fail flag stays set until the next accepted start. A one-cycle done pulse ends the run.

Top module: `mbist_ctrl`

## Requirements
- R1: After reset, done, fail and mem_we are 0 and fail_addr, fail_elem and fail_bg are 0.
- R2: start is taken only while the block is idle. A start pulse during a run has no effect: the run keeps its mode and its length.
- R3: The mode is latched at start. 0 selects the six-op march: up(w0); up(r0,w1); down(r1,w0,r0). 1 selects the walking march: up(w0); up(r0,w1,r1); down(r1,w0,r0); up(w1); up(r1,w0,r0); down(r0,w1,r1). 2 and 3 select the merged mode. Here 0 means the background and 1 its complement.
- R4: An ascending element visits addresses 0 to N-1. A descending element visits N-1 down to 0. An element without a fixed order is walked ascending. Exactly one operation is issued per clock cycle, with no gaps.
- R5: For W-bit words there are log2(W)+1 backgrounds. Background 0 is all zeros. In background k>=1, bit i is 1 exactly when bit k-1 of i is 0. For W=8 the backgrounds are 0x00, 0x55, 0x33 and 0x0F.
- R6: Modes 0 and 1 run their whole element list once per background, in background order 0 upward. They issue 6N and 14N operations per background.
- R7: The merged mode runs up(w0); up(r0,w1); up(r1,w0); down(r0,w1); down(r1,w0); any(r0) with background 0. It then runs up(w0); up(r0,w1); down(r1,w0) with each later background, for (10+5*log2 W)*N operations in total.
- R8: A write puts the background or its complement on mem_wdata. A read compares mem_rdata, taken one cycle after the read is issued, against the same expected word.
- R9: The first miscompare sets fail and captures the read's address, element index and background index. Later miscompares change none of these. An accepted start clears them all.
- R10: done is high for exactly one cycle. It rises two cycles after the cycle of the final operation.
- R11: A miscompare on the very last read of a run is reported with fail already set in the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test (taken only when idle) |
| mode | input | 2 | Algorithm select, latched at start |
| mem_addr | output | AW | SRAM word address |
| mem_we | output | 1 | SRAM write enable |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, one cycle after the address |
| done | output | 1 | One-cycle end-of-test pulse |
| fail | output | 1 | Sticky miscompare flag |
| fail_addr | output | AW | Address of the first miscompare |
| fail_elem | output | 3 | Element index of the first miscompare |
| fail_bg | output | BGW | Background index of the first miscompare |

## Verification
Two events can land together. The first is the compare of the final read, which falls in the drain cycle just before done; the bench corrupts only that read and expects fail low one cycle before done and high in the done cycle, with address 0, element 2 and the last background. The second is a start arriving while a run is busy; the bench pulses start with a different mode partway through a run and requires the run length, the descending start address and a single done to stay as the original mode dictates. Stuck bits and an intra-word bridge, which only a non-solid background reveals, check the capture location against hand-derived values.

// File: rtl/mbist_pkg.sv
package mbist_pkg;

   localparam logic [1:0] MODE_SIX     = 2'd0;
   localparam logic [1:0] MODE_WALK    = 2'd1;
   localparam logic [1:0] MODE_MERGED  = 2'd2;

   localparam logic [1:0] DIR_UP  = 2'd0;
   localparam logic [1:0] DIR_DN  = 2'd1;
   localparam logic [1:0] DIR_ANY = 2'd2;

   localparam int ELEM_W = 3;

   typedef struct packed {
      logic wr;
      logic inv;
   } op_t;

   localparam op_t OP_R0 = 2'b00;
   localparam op_t OP_R1 = 2'b01;
   localparam op_t OP_W0 = 2'b10;
   localparam op_t OP_W1 = 2'b11;

   typedef struct packed {
      logic [1:0]      dir;
      logic [1:0]      nops;
      op_t  [2:0]      ops;
   } elem_t;

   function automatic elem_t mk(logic [1:0] d, logic [1:0] n, op_t a, op_t b, op_t c);
      elem_t e;
      e.dir    = d;
      e.nops   = n;
      e.ops[0] = a;
      e.ops[1] = b;
      e.ops[2] = c;
      return e;
   endfunction

   function automatic elem_t elem_lookup(logic [1:0] mode, logic solid, logic [ELEM_W-1:0] idx);
      elem_t e;
      e = mk(DIR_UP, 2'd1, OP_W0, OP_R0, OP_R0);
      if (mode == MODE_SIX) begin
         case (idx)
            3'd1:    e = mk(DIR_UP, 2'd2, OP_R0, OP_W1, OP_R0);
            3'd2:    e = mk(DIR_DN, 2'd3, OP_R1, OP_W0, OP_R0);
            default: e = mk(DIR_UP, 2'd1, OP_W0, OP_R0, OP_R0);
         endcase
      end else if (mode == MODE_WALK) begin
         case (idx)
            3'd1:    e = mk(DIR_UP, 2'd3, OP_R0, OP_W1, OP_R1);
            3'd2:    e = mk(DIR_DN, 2'd3, OP_R1, OP_W0, OP_R0);
            3'd3:    e = mk(DIR_UP, 2'd1, OP_W1, OP_R0, OP_R0);
            3'd4:    e = mk(DIR_UP, 2'd3, OP_R1, OP_W0, OP_R0);
            3'd5:    e = mk(DIR_DN, 2'd3, OP_R0, OP_W1, OP_R1);
            default: e = mk(DIR_UP, 2'd1, OP_W0, OP_R0, OP_R0);
         endcase
      end else if (solid) begin
         case (idx)
            3'd1:    e = mk(DIR_UP,  2'd2, OP_R0, OP_W1, OP_R0);
            3'd2:    e = mk(DIR_UP,  2'd2, OP_R1, OP_W0, OP_R0);
            3'd3:    e = mk(DIR_DN,  2'd2, OP_R0, OP_W1, OP_R0);
            3'd4:    e = mk(DIR_DN,  2'd2, OP_R1, OP_W0, OP_R0);
            3'd5:    e = mk(DIR_ANY, 2'd1, OP_R0, OP_R0, OP_R0);
            default: e = mk(DIR_UP,  2'd1, OP_W0, OP_R0, OP_R0);
         endcase
      end else begin
         case (idx)
            3'd1:    e = mk(DIR_UP, 2'd2, OP_R0, OP_W1, OP_R0);
            3'd2:    e = mk(DIR_DN, 2'd2, OP_R1, OP_W0, OP_R0);
            default: e = mk(DIR_UP, 2'd1, OP_W0, OP_R0, OP_R0);
         endcase
      end
      return e;
   endfunction

   function automatic logic elem_is_down(logic [1:0] mode, logic solid, logic [ELEM_W-1:0] idx);
      elem_t e;
      e = elem_lookup(mode, solid, idx);
      return (e.dir == DIR_DN);
   endfunction

   function automatic logic [ELEM_W-1:0] elem_count(logic [1:0] mode, logic solid);
      if (mode == MODE_SIX)  return 3'd3;
      if (mode == MODE_WALK) return 3'd6;
      if (solid)             return 3'd6;
      return 3'd3;
   endfunction

endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
   parameter int DEPTH = 16,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_dn,
   input  logic          step,
   input  logic          cur_dn,
   output logic [AW-1:0] addr,
   output logic          at_last
);

   localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

   assign at_last = cur_dn ? (addr == '0) : (addr == TOP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr <= '0;
      end else if (load) begin
         addr <= load_dn ? TOP : '0;
      end else if (step) begin
         addr <= cur_dn ? addr - 1'b1 : addr + 1'b1;
      end
   end

   AST_ADDR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load && !at_last) |=> (addr != $past(addr)) &&
         ((addr == $past(addr) + 1'b1) || (addr == $past(addr) - 1'b1))) // R4
      else $error("address did not move by one");

endmodule

// File: rtl/mbist_pattern.sv
module mbist_pattern #(
   parameter int DATA_W = 8,
   parameter int BGW    = 2
) (
   input  logic [BGW-1:0]    bg,
   input  logic              inv,
   output logic [DATA_W-1:0] data
);

   logic [BGW-1:0]    sh;
   logic [DATA_W-1:0] base;

   assign sh = bg - 1'b1;

   for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam logic [31:0] IDXV = 32'(i);
      assign base[i] = (bg == '0) ? 1'b0 : ~IDXV[sh];
   end

   assign data = base ^ {DATA_W{inv}};

endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int DATA_W = 8,
   parameter int AW     = 4,
   parameter int EW     = 3,
   parameter int BGW    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear,
   input  logic              rd_issue,
   input  logic [DATA_W-1:0] exp_in,
   input  logic [AW-1:0]     addr_in,
   input  logic [EW-1:0]     elem_in,
   input  logic [BGW-1:0]    bg_in,
   input  logic [DATA_W-1:0] rdata,
   output logic              fail,
   output logic [AW-1:0]     fail_addr,
   output logic [EW-1:0]     fail_elem,
   output logic [BGW-1:0]    fail_bg
);

   logic              pend_q;
   logic [DATA_W-1:0] exp_q;
   logic [AW-1:0]     addr_q;
   logic [EW-1:0]     elem_q;
   logic [BGW-1:0]    bg_q;
   logic              miss;

   assign miss = pend_q && (rdata != exp_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         exp_q  <= '0;
         addr_q <= '0;
         elem_q <= '0;
         bg_q   <= '0;
      end else begin
         pend_q <= rd_issue;
         if (rd_issue) begin
            exp_q  <= exp_in;
            addr_q <= addr_in;
            elem_q <= elem_in;
            bg_q   <= bg_in;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
         fail_bg   <= '0;
      end else if (clear) begin
         fail      <= 1'b0;
         fail_addr <= '0;
         fail_elem <= '0;
         fail_bg   <= '0;
      end else if (miss && !fail) begin
         fail      <= 1'b1;
         fail_addr <= addr_q;
         fail_elem <= elem_q;
         fail_bg   <= bg_q;
      end
   end

   AST_MISS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && (rdata != exp_q) && !clear) |=> fail) // R8
      else $error("miscompare not flagged");

   AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> fail) // R9
      else $error("fail dropped without start");

   AST_CAPTURE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fail && !clear) |=> ($stable(fail_addr) && $stable(fail_elem) && $stable(fail_bg))) // R9
      else $error("captured location changed");

endmodule

// File: rtl/mbist_ctrl.sv
module mbist_ctrl
   import mbist_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int AW    = $clog2(DEPTH),
   localparam int NBG   = $clog2(DATA_W) + 1,
   localparam int BGW   = $clog2(NBG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        mode,
   output logic [AW-1:0]     mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              fail,
   output logic [AW-1:0]     fail_addr,
   output logic [ELEM_W-1:0] fail_elem,
   output logic [BGW-1:0]    fail_bg
);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two, at least 2");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN, ST_FIN} state_e;

   localparam logic [BGW-1:0] LAST_BG = BGW'(NBG - 1);

   state_e            state_q;
   logic [1:0]        mode_q;
   logic [BGW-1:0]    bg_q;
   logic [ELEM_W-1:0] elem_q;
   logic [1:0]        op_q;

   elem_t             cur;
   op_t               cur_op;
   logic              solid;
   logic              run;
   logic              start_acc;
   logic              last_op, last_elem, last_bg, at_last;
   logic              nxt_solid;
   logic [ELEM_W-1:0] nxt_idx;
   logic              ag_load, ag_load_dn, ag_step;
   logic [DATA_W-1:0] pat;

   assign solid     = (bg_q == '0);
   assign cur       = elem_lookup(mode_q, solid, elem_q);
   assign cur_op    = cur.ops[op_q];
   assign run       = (state_q == ST_RUN);
   assign start_acc = (state_q == ST_IDLE) && start;

   assign last_op   = (op_q == cur.nops - 2'd1);
   assign last_elem = (elem_q == elem_count(mode_q, solid) - 3'd1);
   assign last_bg   = (bg_q == LAST_BG);

   assign nxt_solid = last_elem ? 1'b0 : solid;
   assign nxt_idx   = last_elem ? '0 : elem_q + 3'd1;

   assign ag_load    = start_acc || (run && last_op && at_last && !(last_elem && last_bg));
   assign ag_load_dn = start_acc ? elem_is_down(mode, 1'b1, '0)
                                 : elem_is_down(mode_q, nxt_solid, nxt_idx);
   assign ag_step    = run && last_op && !at_last;

   mbist_addr_gen #(.DEPTH(DEPTH)) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (ag_load),
      .load_dn (ag_load_dn),
      .step    (ag_step),
      .cur_dn  (cur.dir == DIR_DN),
      .addr    (mem_addr),
      .at_last (at_last)
   );

   mbist_pattern #(.DATA_W(DATA_W), .BGW(BGW)) u_pat (
      .bg   (bg_q),
      .inv  (cur_op.inv),
      .data (pat)
   );

   assign mem_we    = run && cur_op.wr;
   assign mem_wdata = pat;
   assign done      = (state_q == ST_FIN);

   mbist_cmp #(.DATA_W(DATA_W), .AW(AW), .EW(ELEM_W), .BGW(BGW)) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (start_acc),
      .rd_issue  (run && !cur_op.wr),
      .exp_in    (pat),
      .addr_in   (mem_addr),
      .elem_in   (elem_q),
      .bg_in     (bg_q),
      .rdata     (mem_rdata),
      .fail      (fail),
      .fail_addr (fail_addr),
      .fail_elem (fail_elem),
      .fail_bg   (fail_bg)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= MODE_SIX;
         bg_q    <= '0;
         elem_q  <= '0;
         op_q    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start) begin
                  state_q <= ST_RUN;
                  mode_q  <= mode;
                  bg_q    <= '0;
                  elem_q  <= '0;
                  op_q    <= '0;
               end
            end
            ST_RUN: begin
               if (!last_op) begin
                  op_q <= op_q + 2'd1;
               end else begin
                  op_q <= '0;
                  if (at_last) begin
                     if (last_elem) begin
                        elem_q <= '0;
                        if (last_bg) state_q <= ST_DRAIN;
                        else         bg_q    <= bg_q + 1'b1;
                     end else begin
                        elem_q <= elem_q + 3'd1;
                     end
                  end
               end
            end
            ST_DRAIN: state_q <= ST_FIN;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done) // R10
      else $error("done longer than one cycle");

   AST_BG_NO_REWIND: assert property (@(posedge clk) disable iff (!rst_n)
      (run && start) |=> (bg_q >= $past(bg_q))) // R2
      else $error("start during run rewound the test");

   AST_DONE_AFTER_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> ($past(state_q) == ST_DRAIN)) // R10
      else $error("done without drain cycle");

endmodule

// File: tb/mbist_ctrl_tb_top.sv
module mbist_ctrl_tb_top;

   localparam int W  = 8;
   localparam int N  = 16;
   localparam int AW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [1:0]    mode = 2'd0;
   logic [AW-1:0] mem_addr;
   logic          mem_we;
   logic [W-1:0]  mem_wdata;
   logic [W-1:0]  mem_rdata;
   logic          done, fail;
   logic [AW-1:0] fail_addr;
   logic [2:0]    fail_elem;
   logic [1:0]    fail_bg;

   always #10 clk = ~clk;

   mbist_ctrl #(.DATA_W(W), .DEPTH(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .fail(fail),
      .fail_addr(fail_addr), .fail_elem(fail_elem), .fail_bg(fail_bg)
   );

   // memory model with fault injection: 0 none, 1 stuck bit, 2 bit1 bridged to bit0, 3 flip one read
   logic [W-1:0] mem [N];
   int           f_kind = 0;
   int           f_addr = 0;
   int           f_bit  = 0;
   logic         f_val  = 1'b0;
   logic         flip_now = 1'b0;
   logic [W-1:0] rd;

   initial for (int i = 0; i < N; i++) mem[i] = '0;

   always @(posedge clk) begin
      rd = mem[mem_addr];
      if (f_kind == 1 && int'(mem_addr) == f_addr) rd[f_bit] = f_val;
      if (f_kind == 2) rd[1] = rd[0];
      if (f_kind == 3 && flip_now) rd[0] = ~rd[0];
      mem_rdata <= rd;
      if (mem_we) mem[mem_addr] <= mem_wdata;
   end

   int n_chk = 0;
   int n_err = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   logic [AW-1:0] a_log [1024];
   logic          w_log [1024];
   logic [W-1:0]  d_log [1024];
   logic          f_log [1024];
   int            k_done;
   bit            done_after;

   // runs one test; op k is the cycle after start edge + k
   task automatic run(input logic [1:0] m, input int flip_idx, input int mid_k);
      k_done = -1;
      @(negedge clk);
      mode  = m;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      for (int k = 0; k < 5000; k++) begin
         if (k < 1024) begin
            a_log[k] = mem_addr; w_log[k] = mem_we; d_log[k] = mem_wdata; f_log[k] = fail;
         end
         flip_now = (k == flip_idx);
         start    = (k == mid_k);
         if (k == mid_k) mode = 2'd1;
         if (done) begin
            k_done = k;
            break;
         end
         @(negedge clk);
      end
      start = 1'b0;
      flip_now = 1'b0;
      @(negedge clk);
      done_after = done;
      if (k_done < 0) chk(0, "R10 run timeout", k_done, 0);
   endtask

   task automatic mem_all(input logic [W-1:0] v, input string tag);
      bit ok = 1;
      for (int i = 0; i < N; i++) if (mem[i] !== v) ok = 0;
      chk(ok, tag, int'(mem[0]), int'(v));
   endtask

   task automatic t_reset;
      chk(done == 0 && fail == 0 && mem_we == 0, "R1 reset outputs", int'({done, fail, mem_we}), 0);
      chk(fail_addr == 0 && fail_elem == 0 && fail_bg == 0, "R1 reset capture",
          int'({fail_addr, fail_elem, fail_bg}), 0);
   endtask

   task automatic t_six;
      f_kind = 0;
      run(2'd0, -1, -1);
      chk(k_done == 6*N*4 + 1, "R6 R10 six-op latency", k_done, 6*N*4 + 1);
      chk(done_after == 0, "R10 done one cycle", int'(done_after), 0);
      chk(fail == 0, "R8 clean run", int'(fail), 0);
      chk(w_log[0] && a_log[0] == 0 && d_log[0] == 8'h00, "R3 first op w0", int'(d_log[0]), 0);
      chk(!w_log[N] && a_log[N] == 0, "R3 r0 at address 0", int'(w_log[N]), 0);
      chk(w_log[N+1] && d_log[N+1] == 8'hFF, "R8 w1 complement", int'(d_log[N+1]), 255);
      chk(a_log[3*N] == 4'd15 && !w_log[3*N], "R4 descending starts at top", int'(a_log[3*N]), 15);
      chk(a_log[3*N+3] == 4'd14, "R4 descending steps down", int'(a_log[3*N+3]), 14);
      chk(d_log[6*N] == 8'h55, "R5 background 1", int'(d_log[6*N]), 85);
      chk(d_log[12*N] == 8'h33, "R5 background 2", int'(d_log[12*N]), 51);
      chk(d_log[18*N] == 8'h0F, "R5 background 3", int'(d_log[18*N]), 15);
      mem_all(8'h0F, "R6 final contents six-op");
   endtask

   task automatic t_walk;
      f_kind = 0;
      run(2'd1, -1, -1);
      chk(k_done == 14*N*4 + 1, "R6 walking latency", k_done, 14*N*4 + 1);
      chk(w_log[7*N] && d_log[7*N] == 8'hFF, "R3 walking w1 element", int'(d_log[7*N]), 255);
      chk(a_log[4*N] == 4'd15, "R4 walking descending", int'(a_log[4*N]), 15);
      chk(fail == 0, "R8 walking clean", int'(fail), 0);
      mem_all(8'hF0, "R6 final contents walking");
   endtask

   task automatic t_merged;
      f_kind = 0;
      run(2'd2, -1, -1);
      chk(k_done == 25*N + 1, "R7 merged latency", k_done, 25*N + 1);
      chk(a_log[9*N] == 0 && a_log[9*N+1] == 1, "R4 any-order walked ascending",
          int'(a_log[9*N+1]), 1);
      chk(w_log[10*N] && d_log[10*N] == 8'h55, "R7 short march bg1", int'(d_log[10*N]), 85);
      chk(w_log[11*N+1] && d_log[11*N+1] == 8'hAA, "R8 bg1 complement", int'(d_log[11*N+1]), 170);
      chk(a_log[13*N] == 4'd15 && !w_log[13*N], "R4 short descending", int'(a_log[13*N]), 15);
      chk(d_log[15*N] == 8'h33, "R7 short march bg2", int'(d_log[15*N]), 51);
      mem_all(8'h0F, "R7 final contents merged");
      run(2'd3, -1, -1);
      chk(k_done == 25*N + 1, "R3 mode 3 is merged", k_done, 25*N + 1);
   endtask

   task automatic t_stuck_one;
      f_kind = 1; f_addr = 5; f_bit = 3; f_val = 1'b1;
      run(2'd0, -1, -1);
      chk(fail == 1, "R9 stuck-at-1 fail", int'(fail), 1);
      chk(fail_addr == 5 && fail_elem == 1 && fail_bg == 0, "R9 first capture kept",
          int'({fail_addr, fail_elem, fail_bg}), int'({4'd5, 3'd1, 2'd0}));
      f_kind = 0;
   endtask

   task automatic t_stuck_zero;
      f_kind = 1; f_addr = 9; f_bit = 0; f_val = 1'b0;
      run(2'd2, -1, -1);
      chk(fail_addr == 9 && fail_elem == 2 && fail_bg == 0, "R9 stuck-at-0 merged",
          int'({fail_addr, fail_elem, fail_bg}), int'({4'd9, 3'd2, 2'd0}));
      f_kind = 0;
   endtask

   task automatic t_bridge;
      f_kind = 2;
      run(2'd2, -1, -1);
      chk(fail_addr == 0 && fail_elem == 1 && fail_bg == 1, "R5 bridge found at bg1",
          int'({fail_addr, fail_elem, fail_bg}), int'({4'd0, 3'd1, 2'd1}));
      f_kind = 0;
   endtask

   task automatic t_clear;
      run(2'd0, -1, -1);
      chk(f_log[1] == 0, "R9 start clears fail", int'(f_log[1]), 0);
      chk(fail == 0 && fail_addr == 0, "R9 clean rerun", int'(fail), 0);
   endtask

   task automatic t_last_read;
      f_kind = 3;
      run(2'd0, 6*N*4 - 1, -1);
      chk(f_log[6*N*4] == 0, "R11 fail low in drain", int'(f_log[6*N*4]), 0);
      chk(fail == 1 && fail_addr == 0 && fail_elem == 2 && fail_bg == 3, "R11 last read capture",
          int'({fail, fail_addr, fail_elem, fail_bg}), int'({1'b1, 4'd0, 3'd2, 2'd3}));
      chk(f_log[6*N*4 + 1] == 1, "R11 fail with done", int'(f_log[6*N*4 + 1]), 1);
      f_kind = 0;
   endtask

   task automatic t_mid_start;
      f_kind = 0;
      run(2'd0, -1, 100);
      chk(k_done == 6*N*4 + 1, "R2 start ignored while busy", k_done, 6*N*4 + 1);
      chk(a_log[9*N] == 4'd15, "R2 mode kept", int'(a_log[9*N]), 15);
      chk(done_after == 0, "R2 single done", int'(done_after), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_six();
      t_walk();
      t_merged();
      t_stuck_one();
      t_clear();
      t_stuck_zero();
      t_bridge();
      t_last_read();
      t_mid_start();
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

endmodule